// File: doc/BRIEF.md
# Vector Immediate Logic and Shuffle Unit

This unit is one execution stage for a 128-bit vector datapath. Each accepted request carries a source vector, the current value of the destination vector, an 8-bit immediate and an operation code. One clock later the unit returns the new destination vector. The operations fall into three groups:

- Bytewise logic with the immediate.
- Bit-merges that mix the source with the old destination under a mask.
- Permutations that reorder elements inside each group of four, steered by 2-bit fields of the immediate.

The register file, instruction decode and exception handling sit outside the unit. Lane 0 is always the least significant slice of a vector.

Top module: `vimm_unit`

## Requirements
- R1: Vectors are 128 bits wide and lanes are little-endian. Byte lane n is bits [8n+7:8n], halfword lane n is bits [16n+15:16n], and word lane n is bits [32n+31:32n].
- R2: Op 0 gives src AND imm, op 1 gives src OR imm, and op 3 gives src XOR imm. In each case the 8-bit immediate is applied to every byte lane.
- R3: Op 2 gives, in every byte lane, the complement of (src OR imm).
- R4: Op 4 gives, in every byte lane, (src AND imm) OR (dst AND NOT imm). Bits where the immediate is 1 come from the source.
- R5: Op 5 gives, in every byte lane, (src AND NOT imm) OR (dst AND imm).
- R6: Op 6 gives, in every byte lane, (src AND NOT dst) OR (dst AND imm). The old destination acts as the mask.
- R7: Op 7 shuffles byte lanes and op 8 shuffles halfword lanes. Output element i, with j = i mod 4, is source element i - j + imm[2j+1:2j], so each group of four elements is permuted independently.
- R8: Op 9 shuffles word lanes. Output word i is source word number imm[2i+1:2i].
- R9: The immediate 0xE4 returns the source unchanged for ops 7, 8 and 9.
- R10: Op codes 10 to 15 return the old destination unchanged and raise the error output for that result.
- R11: A request accepted while the request-valid input is high produces its result, with the result-valid output high, exactly one clock later. A cycle with no request leaves the result-valid and error outputs low. Reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_imm | input | 8 | Immediate operand |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Current destination vector |
| res_valid | output | 1 | Result present |
| res_vec | output | 128 | New destination vector |
| res_err | output | 1 | Unsupported operation flag |

## Verification
On every cycle the assertions check the timing relation between request-valid and result-valid, and that an error result is valid and carries the old destination. They also check that the identity immediate on a word shuffle returns the source. The arithmetic of each merge, the lane order and the grouping of the byte and halfword permutations can only be shown by the bench. It compares every result against an independent reference over random vectors, and it also uses the immediates 0x00, 0xFF and 0xE4.

// File: rtl/vimm_pkg.sv
package vimm_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    VOP_AND  = 4'd0,
    VOP_OR   = 4'd1,
    VOP_NOR  = 4'd2,
    VOP_XOR  = 4'd3,
    VOP_MNZ  = 4'd4,
    VOP_MZ   = 4'd5,
    VOP_SEL  = 4'd6,
    VOP_SHFB = 4'd7,
    VOP_SHFH = 4'd8,
    VOP_SHFW = 4'd9
  } vop_e;

  function automatic logic op_supported(input logic [OP_W-1:0] op);
    return op <= 4'd9;
  endfunction
endpackage

// File: rtl/vimm_bitops.sv
// Bytewise logic and bit-merge operations (R2..R6).
module vimm_bitops
  import vimm_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [BYTE_W-1:0] imm,
  input  logic [VEC_W-1:0]  src,
  input  logic [VEC_W-1:0]  dst,
  output logic [VEC_W-1:0]  res
);
  localparam int LANES = VEC_W / BYTE_W;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [BYTE_W-1:0] s, d, r;
    assign s = src[n*BYTE_W +: BYTE_W];
    assign d = dst[n*BYTE_W +: BYTE_W];
    always_comb begin
      case (op)
        VOP_AND: r = s & imm;
        VOP_OR:  r = s | imm;
        VOP_NOR: r = ~(s | imm);
        VOP_XOR: r = s ^ imm;
        VOP_MNZ: r = (s & imm) | (d & ~imm);
        VOP_MZ:  r = (s & ~imm) | (d & imm);
        VOP_SEL: r = (s & ~d) | (d & imm);
        default: r = d;
      endcase
    end
    assign res[n*BYTE_W +: BYTE_W] = r;
  end
endmodule

// File: rtl/vimm_shuffle.sv
// Permutation within groups of four elements of width ELEM_W (R7, R8).
module vimm_shuffle #(
  parameter int VEC_W  = 128,
  parameter int ELEM_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] src,
  output logic [VEC_W-1:0] res
);
  localparam int GROUP = 4;
  localparam int LANES = VEC_W / ELEM_W;

  for (genvar i = 0; i < LANES; i++) begin : g_elem
    localparam int J    = i % GROUP;
    localparam int BASE = i - J;
    logic [1:0]        sel;
    logic [ELEM_W-1:0] pick;
    assign sel = imm[2*J +: 2];
    always_comb begin
      case (sel)
        2'd0:    pick = src[(BASE+0)*ELEM_W +: ELEM_W];
        2'd1:    pick = src[(BASE+1)*ELEM_W +: ELEM_W];
        2'd2:    pick = src[(BASE+2)*ELEM_W +: ELEM_W];
        default: pick = src[(BASE+3)*ELEM_W +: ELEM_W];
      endcase
    end
    assign res[i*ELEM_W +: ELEM_W] = pick;
  end
endmodule

// File: rtl/vimm_unit.sv
module vimm_unit
  import vimm_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int IMM_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [3:0]       req_op,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  output logic             res_valid,
  output logic [VEC_W-1:0] res_vec,
  output logic             res_err
);
  localparam int NSHF = 3;

  logic [VEC_W-1:0] bit_res;
  logic [VEC_W-1:0] shf_res [NSHF];
  logic [VEC_W-1:0] nxt_vec;
  logic             nxt_err;

  vimm_bitops #(.VEC_W(VEC_W), .BYTE_W(IMM_W)) u_bitops (
    .op(req_op), .imm(req_imm), .src(src_vec), .dst(dst_vec), .res(bit_res)
  );

  // one shuffle per granularity: byte, halfword, word
  for (genvar g = 0; g < NSHF; g++) begin : g_shf
    vimm_shuffle #(.VEC_W(VEC_W), .ELEM_W(8 << g), .IMM_W(IMM_W)) u_shf (
      .imm(req_imm), .src(src_vec), .res(shf_res[g])
    );
  end

  always_comb begin
    nxt_err = !op_supported(req_op);
    case (req_op)
      VOP_SHFB: nxt_vec = shf_res[0];
      VOP_SHFH: nxt_vec = shf_res[1];
      VOP_SHFW: nxt_vec = shf_res[2];
      default:  nxt_vec = bit_res;   // R10: bitops passes dst for bad codes
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_vec   <= '0;
    end else begin
      res_valid <= req_valid;
      res_err   <= req_valid && nxt_err;
      if (req_valid) res_vec <= nxt_vec;
    end
  end

  // R11: result follows request by exactly one cycle
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid && !res_err);
  // R10: error results are valid and carry the old destination
  a_r10_err_valid: assert property (@(posedge clk) disable iff (rst)
    res_err |-> res_valid);
  a_r10_err_keeps_dst: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op > 4'd9) |=> res_vec == $past(dst_vec));
  // R9: identity immediate on word shuffle
  a_r9_identity_word: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd9 && req_imm == 8'hE4) |=> res_vec == $past(src_vec));
endmodule

// File: tb/vimm_unit_bench.sv
module vimm_unit_bench;
  localparam int VW = 128;

  typedef struct {
    logic [VW-1:0] vec;
    logic          err;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [3:0]    req_op = '0;
  logic [7:0]    req_imm = '0;
  logic [VW-1:0] src_vec = '0;
  logic [VW-1:0] dst_vec = '0;
  logic          res_valid;
  logic [VW-1:0] res_vec;
  logic          res_err;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  vimm_unit u_vimm_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_imm(req_imm), .src_vec(src_vec), .dst_vec(dst_vec),
    .res_valid(res_valid), .res_vec(res_vec), .res_err(res_err)
  );

  function automatic logic [VW-1:0] rvec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Reference model written from the requirements
  function automatic logic [VW-1:0] ref_shuf(input logic [VW-1:0] s,
                                             input logic [7:0] im, input int ew);
    logic [VW-1:0] o = '0;
    for (int i = 0; i < VW/ew; i++) begin
      int j = i % 4;
      int k = (im >> (2*j)) & 3;
      for (int b = 0; b < ew; b++) o[i*ew+b] = s[(i-j+k)*ew+b];
    end
    return o;
  endfunction

  function automatic logic [VW-1:0] ref_model(input logic [3:0] op, input logic [7:0] im,
                                              input logic [VW-1:0] s, input logic [VW-1:0] d);
    logic [VW-1:0] m = {16{im}};
    case (op)
      4'd0: return s & m;
      4'd1: return s | m;
      4'd2: return ~(s | m);
      4'd3: return s ^ m;
      4'd4: return (s & m) | (d & ~m);
      4'd5: return (s & ~m) | (d & m);
      4'd6: return (s & ~d) | (d & m);
      4'd7: return ref_shuf(s, im, 8);
      4'd8: return ref_shuf(s, im, 16);
      4'd9: return ref_shuf(s, im, 32);
      default: return d;
    endcase
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd3: return "R2";
      4'd2: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] im,
                       input logic [VW-1:0] s, input logic [VW-1:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_imm = im; src_vec = s; dst_vec = d;
    e.vec = ref_model(op, im, s, d);
    e.err = (op > 4'd9);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_op = $urandom;
  endtask

  // Monitor: compare each result against the queue head
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected result: actual valid=1 expected valid=0");
      end else begin
        e = sb_q.pop_front();
        if (res_vec !== e.vec || res_err !== e.err) begin
          errors++;
          $display("FAIL %s actual %h err=%b expected %h err=%b",
                   e.tag, res_vec, res_err, e.vec, e.err);
        end
      end
    end else if (!rst && res_err) begin
      checks++; errors++;
      $display("FAIL R11 error without valid: actual err=1 expected err=0");
    end
  end

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] s, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;   // R11 reset state
    if (res_valid !== 1'b0 || res_err !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: actual valid=%b err=%b expected 0 0", res_valid, res_err);
    end

    // R1 lane order: byte shuffle with imm 0x1B reverses each group of four
    s = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    drive(4'd7, 8'h1B, s, '0, "R1");
    drive(4'd9, 8'h1B, s, '0, "R1");
    idle();
    if (ref_shuf(s, 8'h1B, 8) !== 128'h0c0d0e0f_08090a0b_04050607_00010203) begin
      checks++; errors++;
      $display("FAIL R1 reference lane order");
    end

    // corner immediates on every op, including bad codes (R10)
    for (int op = 0; op < 16; op++) begin
      drive(op[3:0], 8'h00, rvec(), rvec(), op_tag(op[3:0]));
      drive(op[3:0], 8'hFF, rvec(), rvec(), op_tag(op[3:0]));
      drive(op[3:0], 8'hE4, rvec(), rvec(), (op >= 7 && op <= 9) ? "R9" : op_tag(op[3:0]));
    end
    idle();

    // R9 identity explicitly
    s = rvec();
    drive(4'd8, 8'hE4, s, rvec(), "R9");

    // random streams, with idle gaps (R11)
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op = $urandom_range(0, 11);
      drive(op, $urandom, rvec(), rvec(), op_tag(op));
      if (n % 7 == 0) idle();
    end
    idle();
    idle();
    idle();

    checks++;   // R11 every request produced a result
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing results: actual %0d pending expected 0", sb_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule